// File: doc/BRIEF.md
# NOR/ADD Datapath Slice with Deferred Shift Writeback

This block is a 16-bit arithmetic slice for a small two-phase processor. During the execute phase it combines a memory-side word with a data-register word, using either the bitwise NOR or the sum with a carry-in. The result appears on the result bus at once, and the carry-out of the sum is reported alongside it. On the clock edge that ends the execute phase, the result is captured in a holding register. During the fetch phase that follows, the holding register, not the ALU, drives the result bus so that it can be written back to a destination register.

The register-side operand can be suppressed to zero. This turns the sum into a move (plus carry-in) and the NOR into a move-complement. Instead of loading the new ALU result, the holding register can shift its current contents left or right by one bit, with the carry-in supplying the bit that enters. A shift therefore acts on the result of the previous instruction.

A flag beside the bus says whether the bus carries data and which source drives it. When neither phase is active, the bus is zero.

Top module: `nor_add_shift_alu`

## Requirements
- R1: With `fn_add`=0 and `exec_ph`=1, `res_bus` equals the bitwise NOR of `mem_opnd` and the effective register operand in the same cycle, `res_valid`=1 and `res_from_hold`=0.
- R2: With `fn_add`=1 and `exec_ph`=1, `res_bus` equals the low 16 bits of `mem_opnd` + effective register operand + `cin`, and `cout` equals bit 16 of that sum.
- R3: With `opnd_zero`=1, the effective register operand is 0 whatever `reg_opnd` holds, so the sum becomes `mem_opnd`+`cin` and the NOR becomes the complement of `mem_opnd`.
- R4: With `fn_add`=0, `cout` is 0.
- R5: A rising clock edge with `exec_ph`=1 and neither single shift control active loads the ALU result into the holding register. With `fetch_ph`=1 and `exec_ph`=0, `res_bus` shows that value, `res_valid`=1 and `res_from_hold`=1.
- R6: An execute edge with `shl`=1 and `shr`=0 makes the holding register {old[14:0], `cin`}, and the ALU output is ignored.
- R7: An execute edge with `shr`=1 and `shl`=0 makes the holding register {`cin`, old[15:1]}, and the ALU output is ignored.
- R8: An execute edge with both `shl` and `shr` at 1 loads the ALU result, as in R5.
- R9: With both phases low, `res_bus`=0, `res_valid`=0 and `res_from_hold`=0. Edges with `exec_ph`=0 leave the holding register unchanged, even when shift controls are high.
- R10: A rising edge with `rst_n`=0 clears the holding register, so the next fetch phase shows 0.
- R11: With `exec_ph` and `fetch_ph` both high, the ALU drives the bus (`res_from_hold`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the holding register |
| mem_opnd | input | 16 | Memory-side operand |
| reg_opnd | input | 16 | Data-register operand |
| fn_add | input | 1 | 1 selects the sum, 0 selects the NOR |
| opnd_zero | input | 1 | 1 forces the register operand to zero |
| cin | input | 1 | Adder carry-in, and the bit that enters on a shift |
| exec_ph | input | 1 | Execute phase strobe |
| fetch_ph | input | 1 | Fetch (writeback) phase strobe |
| shl | input | 1 | Shift the holding register left on the execute edge |
| shr | input | 1 | Shift the holding register right on the execute edge |
| res_bus | output | 16 | Result bus |
| res_valid | output | 1 | Bus carries data from either source |
| res_from_hold | output | 1 | Bus is driven by the holding register |
| cout | output | 1 | Adder carry-out, 0 for NOR |

## Verification
The assertions take two things for granted. The holding register changes only on edges where `exec_ph` is high, and the phase strobes and shift controls are stable around each clock edge. The stimulus changes every input on the falling edge and holds it through the next rising edge. Phases alternate between execute and fetch, with idle cycles, overlapping strobes and simultaneous shifts added only in directed cases, so each rule is examined in isolation.

// File: rtl/nas_pkg.sv
`timescale 1ns/1ps
// Shared types for the NOR/ADD slice.
// Assumes: nothing; holds type definitions only.
package nas_pkg;
    typedef enum logic [1:0] {
        HM_LOAD = 2'd0,
        HM_SHL  = 2'd1,
        HM_SHR  = 2'd2
    } hold_mode_e;

    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,
        SRC_ALU  = 2'd1,
        SRC_HOLD = 2'd2
    } bus_src_e;

    // Pick the holding-register action; an opposing pair of shifts counts as a load
    function automatic hold_mode_e pick_mode(input logic sl, input logic sr);
        if (sl && !sr) return HM_SHL;
        if (sr && !sl) return HM_SHR;
        return HM_LOAD;
    endfunction
endpackage

// File: rtl/nas_alu_core.sv
`timescale 1ns/1ps
// Combinational NOR / add unit.
// Assumes: operands are stable during the execute phase; carry-out matters only for the sum.
module nas_alu_core #(
    parameter int W = 16
) (
    input  logic [W-1:0] mem_opnd,
    input  logic [W-1:0] reg_opnd,
    input  logic         fn_add,
    input  logic         opnd_zero,
    input  logic         cin,
    output logic [W-1:0] alu_res,
    output logic         alu_cout
);
    localparam int SW = W + 1;

    logic [W-1:0]  b_eff;
    logic [SW-1:0] sum_w;

    // Suppress the register-side operand when requested
    always_comb b_eff = opnd_zero ? '0 : reg_opnd;

    // Full-width sum including the carry-in
    always_comb sum_w = {1'b0, mem_opnd} + {1'b0, b_eff} + {{(SW-1){1'b0}}, cin};

    // Select the function and qualify the carry
    always_comb begin
        if (fn_add) begin
            alu_res  = sum_w[W-1:0];
            alu_cout = sum_w[SW-1];
        end else begin
            alu_res  = ~(mem_opnd | b_eff);
            alu_cout = 1'b0;
        end
    end
endmodule

// File: rtl/nas_hold_reg.sv
`timescale 1ns/1ps
// Holding register that captures the ALU result or shifts by one bit.
// Assumes: it updates only on edges where the execute strobe is high; reset is synchronous.
module nas_hold_reg
    import nas_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         exec_ph,
    input  logic         shl,
    input  logic         shr,
    input  logic         cin,
    input  logic [W-1:0] alu_res,
    output logic [W-1:0] hold_q
);
    hold_mode_e   mode;
    logic [W-1:0] hold_d;

    // Decode the shift controls
    always_comb mode = pick_mode(shl, shr);

    // Compute the next contents for an execute edge
    always_comb begin
        unique case (mode)
            HM_SHL:  hold_d = {hold_q[W-2:0], cin};
            HM_SHR:  hold_d = {cin, hold_q[W-1:1]};
            default: hold_d = alu_res;
        endcase
    end

    // Register update: reset clears, execute edges update, all others hold
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= '0;
        else if (exec_ph) hold_q <= hold_d;
    end

    assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_ph && !shl && !shr) |=> (hold_q == $past(alu_res)));
    assert_shl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_ph && shl && !shr) |=> (hold_q == {$past(hold_q[W-2:0]), $past(cin)}));
    assert_shr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_ph && shr && !shl) |=> (hold_q == {$past(cin), $past(hold_q[W-1:1])}));
    assert_both_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_ph && shl && shr) |=> (hold_q == $past(alu_res)));
    assert_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_ph |=> $stable(hold_q));
endmodule

// File: rtl/nas_bus_sel.sv
`timescale 1ns/1ps
// Result bus source selection: ALU in execute, holding register in fetch, zero when idle.
// Assumes: the execute strobe has priority if both phase strobes are high.
module nas_bus_sel
    import nas_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         exec_ph,
    input  logic         fetch_ph,
    input  logic [W-1:0] alu_res,
    input  logic [W-1:0] hold_q,
    output logic [W-1:0] res_bus,
    output logic         res_valid,
    output logic         res_from_hold
);
    bus_src_e src;

    // Choose the bus source from the phase strobes
    always_comb begin
        if (exec_ph)       src = SRC_ALU;
        else if (fetch_ph) src = SRC_HOLD;
        else               src = SRC_IDLE;
    end

    // Drive the bus and its flags
    always_comb begin
        unique case (src)
            SRC_ALU:  res_bus = alu_res;
            SRC_HOLD: res_bus = hold_q;
            default:  res_bus = '0;
        endcase
        res_valid     = (src != SRC_IDLE);
        res_from_hold = (src == SRC_HOLD);
    end

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_ph && !fetch_ph) |-> (res_bus == '0 && !res_valid && !res_from_hold));
    assert_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_ph && !exec_ph) |-> (res_bus == hold_q && res_from_hold));
    assert_exec_prio_R11: assert property (@(posedge clk) disable iff (!rst_n)
        exec_ph |-> (res_bus == alu_res && res_valid && !res_from_hold));
endmodule

// File: rtl/nor_add_shift_alu.sv
`timescale 1ns/1ps
// Top of the NOR/ADD slice with deferred, shift-capable writeback.
// Assumes: execute and fetch phases alternate; register file and memory sit outside.
module nor_add_shift_alu #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] mem_opnd,
    input  logic [W-1:0] reg_opnd,
    input  logic         fn_add,
    input  logic         opnd_zero,
    input  logic         cin,
    input  logic         exec_ph,
    input  logic         fetch_ph,
    input  logic         shl,
    input  logic         shr,
    output logic [W-1:0] res_bus,
    output logic         res_valid,
    output logic         res_from_hold,
    output logic         cout
);
    logic [W-1:0] alu_res;
    logic [W-1:0] hold_q;

    nas_alu_core #(.W(W)) u_alu (
        .mem_opnd (mem_opnd),
        .reg_opnd (reg_opnd),
        .fn_add   (fn_add),
        .opnd_zero(opnd_zero),
        .cin      (cin),
        .alu_res  (alu_res),
        .alu_cout (cout)
    );

    nas_hold_reg #(.W(W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .exec_ph(exec_ph),
        .shl    (shl),
        .shr    (shr),
        .cin    (cin),
        .alu_res(alu_res),
        .hold_q (hold_q)
    );

    nas_bus_sel #(.W(W)) u_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .exec_ph      (exec_ph),
        .fetch_ph     (fetch_ph),
        .alu_res      (alu_res),
        .hold_q       (hold_q),
        .res_bus      (res_bus),
        .res_valid    (res_valid),
        .res_from_hold(res_from_hold)
    );
endmodule

// File: tb/nor_add_shift_alu_bench.sv
`timescale 1ns/1ps
module nor_add_shift_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_opnd = '0, reg_opnd = '0;
    logic        fn_add = 0, opnd_zero = 0, cin = 0;
    logic        exec_ph = 0, fetch_ph = 0, shl = 0, shr = 0;
    logic [15:0] res_bus;
    logic        res_valid, res_from_hold, cout;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] exp_hold = '0;

    always #2.5 clk = ~clk;

    nor_add_shift_alu u_nor_add_shift_alu (
        .clk(clk), .rst_n(rst_n), .mem_opnd(mem_opnd), .reg_opnd(reg_opnd),
        .fn_add(fn_add), .opnd_zero(opnd_zero), .cin(cin), .exec_ph(exec_ph),
        .fetch_ph(fetch_ph), .shl(shl), .shr(shr), .res_bus(res_bus),
        .res_valid(res_valid), .res_from_hold(res_from_hold), .cout(cout)
    );

    typedef struct packed {
        logic [15:0] a;
        logic [15:0] b;
        logic        fn;
        logic        sup;
        logic        ci;
        logic        sl;
        logic        sr;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VT [0:NV-1] = '{
        '{16'hF0F0, 16'h0F00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R1 NOR
        '{16'hFFFF, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 wrap, carry
        '{16'h1234, 16'h1111, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R2 carry-in
        '{16'h8000, 16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},  // R3 move
        '{16'h00FF, 16'hAAAA, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R3 move-complement
        '{16'h1111, 16'h2222, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // R6 shift left
        '{16'h5555, 16'h0101, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R7 shift right
        '{16'h0005, 16'h0003, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},  // R8 both
        '{16'h7777, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R7 shift right, 1 in
        '{16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}   // R1/R4 NOR of zeros
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [16:0] model_alu(input vec_t v);
        logic [15:0] be;
        logic [16:0] s;
        be = v.sup ? 16'h0000 : v.b;
        s  = {1'b0, v.a} + {1'b0, be} + {16'h0000, v.ci};
        if (v.fn) return s;
        return {1'b0, ~(v.a | be)};
    endfunction

    function automatic logic [15:0] model_hold(input vec_t v, input logic [15:0] h);
        logic [16:0] r;
        r = model_alu(v);
        if (v.sl && !v.sr) return {h[14:0], v.ci};
        if (v.sr && !v.sl) return {v.ci, h[15:1]};
        return r[15:0];
    endfunction

    task automatic apply(input vec_t v);
        mem_opnd = v.a; reg_opnd = v.b; fn_add = v.fn; opnd_zero = v.sup;
        cin = v.ci; shl = v.sl; shr = v.sr;
    endtask

    // One execute cycle followed by one fetch cycle, checked against the model
    task automatic run_vec(input vec_t v);
        logic [16:0] r;
        r = model_alu(v);
        @(negedge clk);
        apply(v); exec_ph = 1; fetch_ph = 0;
        #1;
        check("R1/R2/R3 exec bus", res_bus, r[15:0]);
        check("R2/R4 cout", {15'd0, cout}, {15'd0, r[16]});
        check("R1 exec flags", {14'd0, res_valid, res_from_hold}, 16'd2);
        @(negedge clk);
        exp_hold = model_hold(v, exp_hold);
        exec_ph = 0; fetch_ph = 1; shl = 0; shr = 0;
        #1;
        check("R5-R8 fetch bus", res_bus, exp_hold);
        check("R5 fetch flags", {14'd0, res_valid, res_from_hold}, 16'd3);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        // R9 idle after reset
        check("R9 idle bus", res_bus, 16'h0000);
        check("R9 idle flags", {14'd0, res_valid, res_from_hold}, 16'd0);
        // R10 reset value visible in fetch
        @(negedge clk); fetch_ph = 1;
        #1;
        check("R10 reset hold", res_bus, 16'h0000);

        for (int i = 0; i < NV; i++) run_vec(VT[i]);

        // R9: fetch edges with shifts high leave the holding register alone
        @(negedge clk); fetch_ph = 1; exec_ph = 0; shl = 1; cin = 1;
        @(negedge clk); shl = 0; shr = 1;
        @(negedge clk); shr = 0; cin = 0;
        #1;
        check("R9 no update outside exec", res_bus, exp_hold);
        // R9 idle edges with shifts high
        @(negedge clk); fetch_ph = 0; shl = 1;
        #1;
        check("R9 idle bus", res_bus, 16'h0000);
        @(negedge clk); shl = 0; fetch_ph = 1;
        #1;
        check("R9 hold after idle", res_bus, exp_hold);

        // R11: both phases high, the ALU wins
        @(negedge clk);
        mem_opnd = 16'h0F0F; reg_opnd = 16'h0000; fn_add = 0; opnd_zero = 0; cin = 0;
        exec_ph = 1; fetch_ph = 1;
        #1;
        check("R11 priority bus", res_bus, 16'hF0F0);
        check("R11 priority flags", {14'd0, res_valid, res_from_hold}, 16'd2);
        exp_hold = 16'hF0F0;

        // R10: synchronous reset mid-run clears the loaded value
        @(negedge clk); exec_ph = 0; fetch_ph = 1;
        #1;
        check("R5 loaded before reset", res_bus, 16'hF0F0);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        #1;
        exp_hold = 16'h0000;
        check("R10 cleared by reset", res_bus, 16'h0000);

        // R4: NOR that would overflow as a sum still reports no carry
        @(negedge clk);
        mem_opnd = 16'hFFFF; reg_opnd = 16'hFFFF; fn_add = 0; cin = 1; exec_ph = 1; fetch_ph = 0;
        #1;
        check("R4 NOR cout", {15'd0, cout}, 16'd0);
        @(negedge clk); exec_ph = 0; cin = 0;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule